// File: doc/BRIEF.md
# Procedure Return Stack Sequencer

This block performs the stack work of a subroutine return. A single-cycle `start` pulse presents an opcode byte, a 16-bit release count, an operand-size selector, a stack-address-size selector, the current stack pointer, an inclusive window of legal stack addresses and a code-segment limit. The block first checks that every byte it will pop lies inside the stack window. It then reads the return pointer from a synchronous 64-bit stack-memory port. A far return also reads the code selector. Finally it either commits a new instruction pointer, selector and stack pointer with a `done` pulse, or reports a fault and leaves all committed state untouched.

The stack grows downward, so each pop reads a little-endian word at the current pointer and then moves the pointer up by the operand size in bytes. Pointer arithmetic wraps inside the selected stack-address width and leaves the bits above that width as they were. Descriptor checks, privilege changes and paging belong to other blocks.

Top module: `ret_sequencer`

## Requirements
- R1: Opcode C3h is a near return and C2h is a near return with a release count. CBh is a far return and CAh is a far return with a release count. Any other opcode ends the operation with a general-protection fault (`fault_kind` = 2).
- R2: A near return loads `ip_out` from the word at the current stack pointer and leaves `cs_out` unchanged. The stack pointer moves up by the operand size.
- R3: A far return pops the instruction pointer first and the selector second, from the next operand-size slot. `cs_out` takes bits 15:0 of the second word, and the stack pointer moves up by twice the operand size.
- R4: Before any read, the `need` bytes starting at the masked stack pointer must lie inside [`stk_lo`, `stk_hi`]. `need` is the operand size for a near return and twice it for a far return. Otherwise the block raises a stack fault (`fault_kind` = 1) and issues no memory read.
- R5: The popped pointer is masked to the operand size; a 16-bit pop keeps only bits 15:0. If the masked value exceeds `cs_limit`, the block raises a general-protection fault (`fault_kind` = 2).
- R6: After the pops, the immediate is added to the stack pointer for C2h/CAh. The addition wraps within the stack-address width (`stk_size` 0 = 16, 1 = 32, 2 = 64 bits), and the higher bits of `sp_in` are preserved.
- R7: `size_sel` 0, 1 and 2 select 2, 4 and 8 byte operands. `size_sel` 3 selects the default size: with `long_mode` = 1 it is 8 bytes for a near return and 4 bytes for a far return; with `long_mode` = 0 it is 4 bytes.
- R8: `done` and `fault` are one-cycle pulses and never occur together. On a fault, `ip_out`, `cs_out` and `sp_out` keep their previous values.
- R9: Memory reads use `mem_addr` equal to the stack pointer masked to the stack-address width. Read data returns on `mem_rdata` one cycle after `mem_re`, with the lowest-addressed byte in bits 7:0.
- R10: After reset, `ip_out`, `cs_out` and `sp_out` are zero, and `busy`, `done`, `fault` and `mem_re` are low.
- R11: A `start` pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a return |
| opcode | input | 8 | Return opcode byte |
| imm | input | 16 | Bytes to release after the pops |
| size_sel | input | 2 | Operand size: 0=16, 1=32, 2=64, 3=default |
| stk_size | input | 2 | Stack address size: 0=16, 1=32, 2=64 |
| long_mode | input | 1 | Selects the 64-bit-mode defaults |
| sp_in | input | 64 | Stack pointer at start |
| stk_lo | input | 64 | Lowest legal stack byte address |
| stk_hi | input | 64 | Highest legal stack byte address |
| cs_limit | input | 64 | Highest legal instruction pointer |
| mem_re | output | 1 | Stack memory read strobe |
| mem_addr | output | 64 | Stack memory byte address |
| mem_rdata | input | 64 | Read data, one cycle after `mem_re` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Successful completion pulse |
| fault | output | 1 | Fault pulse |
| fault_kind | output | 2 | 0 none, 1 stack, 2 general protection |
| ip_out | output | 64 | Committed instruction pointer |
| cs_out | output | 16 | Committed code selector |
| sp_out | output | 64 | Committed stack pointer |

## Verification
The release addition and the stack-width wrap act on the same stack-pointer update, and both land in the cycle that commits. The bench provokes this by placing the pointer just below the top of a 16-bit or 32-bit window. It then issues a far return with a release count large enough to carry out of the window, and checks that only the low bits wrap while the upper bits of `sp_in` stay intact. The code-limit test and the commit also share one cycle. The bench sets the limit one below the popped pointer and then equal to it, and checks that the first ends in a fault with no state change and the second commits.

// File: rtl/ret_pkg.sv
package ret_pkg;
    localparam int XLEN = 64;
    localparam int SELW = 16;
    localparam int NBW  = 4;

    localparam logic [7:0] OPC_NEAR     = 8'hC3;
    localparam logic [7:0] OPC_NEAR_IMM = 8'hC2;
    localparam logic [7:0] OPC_FAR      = 8'hCB;
    localparam logic [7:0] OPC_FAR_IMM  = 8'hCA;

    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_STACK = 2'd1,
        FK_GPROT = 2'd2
    } fault_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_RIP, ST_WIP, ST_RCS, ST_WCS, ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic           valid;
        logic           far;
        logic           has_imm;
        logic [NBW-1:0] nbytes;
    } ret_ctl_t;

    function automatic logic [XLEN-1:0] addr_mask(input logic [XLEN-1:0] a, input logic [1:0] asz);
        case (asz)
            2'd0:    addr_mask = {{(XLEN-16){1'b0}}, a[15:0]};
            2'd1:    addr_mask = {{(XLEN-32){1'b0}}, a[31:0]};
            default: addr_mask = a;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] sp_advance(input logic [XLEN-1:0] sp,
                                                   input logic [XLEN-1:0] d,
                                                   input logic [1:0] asz);
        case (asz)
            2'd0:    sp_advance = {sp[XLEN-1:16], sp[15:0] + d[15:0]};
            2'd1:    sp_advance = {sp[XLEN-1:32], sp[31:0] + d[31:0]};
            default: sp_advance = sp + d;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] width_mask(input logic [XLEN-1:0] v, input logic [NBW-1:0] nb);
        case (nb)
            4'd2:    width_mask = {{(XLEN-16){1'b0}}, v[15:0]};
            4'd4:    width_mask = {{(XLEN-32){1'b0}}, v[31:0]};
            default: width_mask = v;
        endcase
    endfunction
endpackage

// File: rtl/ret_decode.sv
module ret_decode
    import ret_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [1:0] size_sel,
    input  logic       long_mode,
    output ret_ctl_t   ctl
);
    always_comb begin
        ctl = '0;
        ctl.valid = 1'b1;
        case (opcode)
            OPC_NEAR:     begin ctl.far = 1'b0; ctl.has_imm = 1'b0; end
            OPC_NEAR_IMM: begin ctl.far = 1'b0; ctl.has_imm = 1'b1; end
            OPC_FAR:      begin ctl.far = 1'b1; ctl.has_imm = 1'b0; end
            OPC_FAR_IMM:  begin ctl.far = 1'b1; ctl.has_imm = 1'b1; end
            default:      ctl.valid = 1'b0;
        endcase
        case (size_sel)
            2'd0:    ctl.nbytes = 4'd2;
            2'd1:    ctl.nbytes = 4'd4;
            2'd2:    ctl.nbytes = 4'd8;
            default: ctl.nbytes = (long_mode && !ctl.far) ? 4'd8 : 4'd4;
        endcase
    end
endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk
    import ret_pkg::*;
(
    input  logic [XLEN-1:0] sp,
    input  logic [1:0]      asz,
    input  logic [NBW:0]    need,
    input  logic [XLEN-1:0] lo,
    input  logic [XLEN-1:0] hi,
    output logic [XLEN-1:0] eff_addr,
    output logic            in_bounds
);
    logic [XLEN:0] last_byte;

    always_comb begin
        eff_addr  = addr_mask(sp, asz);
        last_byte = {1'b0, eff_addr} + (XLEN+1)'(need) - (XLEN+1)'(1);
        in_bounds = (eff_addr >= lo) && (last_byte <= {1'b0, hi});
    end
endmodule

// File: rtl/ret_sequencer.sv
module ret_sequencer
    import ret_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic [15:0]      imm,
    input  logic [1:0]       size_sel,
    input  logic [1:0]       stk_size,
    input  logic             long_mode,
    input  logic [XLEN-1:0]  sp_in,
    input  logic [XLEN-1:0]  stk_lo,
    input  logic [XLEN-1:0]  stk_hi,
    input  logic [XLEN-1:0]  cs_limit,
    output logic             mem_re,
    output logic [XLEN-1:0]  mem_addr,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             busy,
    output logic             done,
    output logic             fault,
    output logic [1:0]       fault_kind,
    output logic [XLEN-1:0]  ip_out,
    output logic [SELW-1:0]  cs_out,
    output logic [XLEN-1:0]  sp_out
);
    seq_state_e      state;
    ret_ctl_t        ctl_d, ctl_q;
    logic [1:0]      asz_q;
    logic [15:0]     imm_q;
    logic [XLEN-1:0] lo_q, hi_q, cslim_q, sp_cur, ip_tmp;
    logic [SELW-1:0] cs_tmp;
    logic [NBW:0]    need;
    logic [XLEN-1:0] eff_addr;
    logic            stk_ok;
    logic [XLEN-1:0] release_amt;

    ret_decode u_decode (
        .opcode    (opcode),
        .size_sel  (size_sel),
        .long_mode (long_mode),
        .ctl       (ctl_d)
    );

    assign need = ctl_q.far ? {ctl_q.nbytes, 1'b0} : {1'b0, ctl_q.nbytes};

    ret_stack_chk u_stack_chk (
        .sp        (sp_cur),
        .asz       (asz_q),
        .need      (need),
        .lo        (lo_q),
        .hi        (hi_q),
        .eff_addr  (eff_addr),
        .in_bounds (stk_ok)
    );

    assign busy        = (state != ST_IDLE);
    assign mem_re      = (state == ST_RIP) || (state == ST_RCS);
    assign mem_addr    = eff_addr;
    assign release_amt = ctl_q.has_imm ? {{(XLEN-16){1'b0}}, imm_q} : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            ctl_q      <= '0;
            asz_q      <= '0;
            imm_q      <= '0;
            lo_q       <= '0;
            hi_q       <= '0;
            cslim_q    <= '0;
            sp_cur     <= '0;
            ip_tmp     <= '0;
            cs_tmp     <= '0;
            done       <= 1'b0;
            fault      <= 1'b0;
            fault_kind <= FK_NONE;
            ip_out     <= '0;
            cs_out     <= '0;
            sp_out     <= '0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    ctl_q   <= ctl_d;
                    asz_q   <= stk_size;
                    imm_q   <= imm;
                    lo_q    <= stk_lo;
                    hi_q    <= stk_hi;
                    cslim_q <= cs_limit;
                    sp_cur  <= sp_in;
                    state   <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (!ctl_q.valid) begin
                        fault <= 1'b1; fault_kind <= FK_GPROT; state <= ST_IDLE;
                    end else if (!stk_ok) begin
                        fault <= 1'b1; fault_kind <= FK_STACK; state <= ST_IDLE;
                    end else begin
                        state <= ST_RIP;
                    end
                end
                ST_RIP: state <= ST_WIP;
                ST_WIP: begin
                    ip_tmp <= width_mask(mem_rdata, ctl_q.nbytes);
                    sp_cur <= sp_advance(sp_cur, {{(XLEN-NBW){1'b0}}, ctl_q.nbytes}, asz_q);
                    state  <= ctl_q.far ? ST_RCS : ST_FIN;
                end
                ST_RCS: state <= ST_WCS;
                ST_WCS: begin
                    cs_tmp <= mem_rdata[SELW-1:0];
                    sp_cur <= sp_advance(sp_cur, {{(XLEN-NBW){1'b0}}, ctl_q.nbytes}, asz_q);
                    state  <= ST_FIN;
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                    if (ip_tmp > cslim_q) begin
                        fault <= 1'b1; fault_kind <= FK_GPROT;
                    end else begin
                        ip_out     <= ip_tmp;
                        if (ctl_q.far) cs_out <= cs_tmp;
                        sp_out     <= sp_advance(sp_cur, release_amt, asz_q);
                        fault_kind <= FK_NONE;
                        done       <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Reads stay inside the stack window latched at start
    assert_read_in_window_R4: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> (mem_addr >= lo_q) &&
                   (({1'b0, mem_addr} + (XLEN+1)'(ctl_q.nbytes) - (XLEN+1)'(1)) <= {1'b0, hi_q}));

    assert_near_keeps_sel_R2: assert property (@(posedge clk) disable iff (rst)
        (done && !ctl_q.far) |-> $stable(cs_out));

    assert_narrow_ip_R5: assert property (@(posedge clk) disable iff (rst)
        (done && ctl_q.nbytes == 4'd2) |-> (ip_out[XLEN-1:16] == '0));

    assert_fault_no_commit_R8: assert property (@(posedge clk) disable iff (rst)
        fault |-> ($stable(ip_out) && $stable(cs_out) && $stable(sp_out)));

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));

    assert_pulse_done_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_pulse_fault_R8: assert property (@(posedge clk) disable iff (rst)
        fault |=> !fault);

    assert_fault_kind_set_R8: assert property (@(posedge clk) disable iff (rst)
        fault |-> (fault_kind != FK_NONE));
endmodule

// File: tb/ret_sequencer_bench.sv
module ret_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] imm = 16'h0;
    logic [1:0]  size_sel = 2'd0;
    logic [1:0]  stk_size = 2'd0;
    logic        long_mode = 1'b0;
    logic [63:0] sp_in = '0, stk_lo = '0, stk_hi = '0, cs_limit = '0;
    logic        mem_re;
    logic [63:0] mem_addr;
    logic [63:0] mem_rdata = '0;
    logic        busy, done, fault;
    logic [1:0]  fault_kind;
    logic [63:0] ip_out, sp_out;
    logic [15:0] cs_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic        seen_rd = 1'b0;
    logic [63:0] first_addr = '0;
    logic [63:0] e_ip = '0, e_sp = '0;
    logic [15:0] e_cs = '0;

    always #2 clk = ~clk;

    ret_sequencer u_ret_sequencer (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .imm(imm),
        .size_sel(size_sel), .stk_size(stk_size), .long_mode(long_mode),
        .sp_in(sp_in), .stk_lo(stk_lo), .stk_hi(stk_hi), .cs_limit(cs_limit),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fault(fault), .fault_kind(fault_kind),
        .ip_out(ip_out), .cs_out(cs_out), .sp_out(sp_out)
    );

    function automatic logic [63:0] pat(input logic [63:0] a);
        return {~a[31:0], a[31:0] ^ 32'h5A5A_0F0F};
    endfunction

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= pat(mem_addr);
        if (mem_re && !seen_rd) begin
            seen_rd    <= 1'b1;
            first_addr <= mem_addr;
        end
    end

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
            finish_run();
        end
    end

    function automatic logic [63:0] wmask(input logic [1:0] s);
        return (s == 2'd0) ? 64'hFFFF : (s == 2'd1) ? 64'hFFFF_FFFF : '1;
    endfunction

    function automatic logic [63:0] wadd(input logic [63:0] a, input logic [63:0] d, input logic [1:0] s);
        return (a & ~wmask(s)) | ((a + d) & wmask(s));
    endfunction

    task automatic run_case(input string tag, input logic [7:0] op, input logic [1:0] sel,
                            input logic lm, input logic [1:0] ssz, input logic [63:0] sp,
                            input logic [15:0] im, input logic [63:0] lo, input logic [63:0] hi,
                            input logic [63:0] clim);
        logic        valid, far, hasimm;
        int          osz, need, waited;
        logic [63:0] a0, a1, sp1, vm, xip, xsp;
        logic [15:0] xcs;
        logic [1:0]  xkind;
        valid  = (op == 8'hC3) || (op == 8'hC2) || (op == 8'hCB) || (op == 8'hCA);
        far    = (op == 8'hCB) || (op == 8'hCA);
        hasimm = (op == 8'hC2) || (op == 8'hCA);
        osz    = (sel == 2'd0) ? 2 : (sel == 2'd1) ? 4 : (sel == 2'd2) ? 8 : ((lm && !far) ? 8 : 4);
        need   = far ? 2 * osz : osz;
        vm     = (osz == 8) ? '1 : ((64'd1 << (8 * osz)) - 64'd1);
        a0     = sp & wmask(ssz);
        sp1    = wadd(sp, 64'(osz), ssz);
        a1     = sp1 & wmask(ssz);
        xip    = pat(a0) & vm;
        xcs    = pat(a1)[15:0];
        xsp    = wadd(far ? wadd(sp1, 64'(osz), ssz) : sp1, hasimm ? 64'(im) : 64'd0, ssz);
        if (!valid) xkind = 2'd2;
        else if (a0 < lo || ({1'b0, a0} + 65'(need) - 65'd1) > {1'b0, hi}) xkind = 2'd1;
        else if (xip > clim) xkind = 2'd2;
        else xkind = 2'd0;

        @(negedge clk);
        seen_rd = 1'b0;
        opcode = op; size_sel = sel; long_mode = lm; stk_size = ssz; sp_in = sp;
        imm = im; stk_lo = lo; stk_hi = hi; cs_limit = clim; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!done && !fault && waited < 30) begin
            @(negedge clk);
            waited++;
        end
        chk(tag, "completed", 64'(done | fault), 64'd1);
        chk(tag, "fault kind", 64'(fault ? fault_kind : 2'd0), 64'(xkind));
        if (xkind == 2'd0) begin
            e_ip = xip; e_sp = xsp;
            if (far) e_cs = xcs;
        end
        chk(tag, "ip_out", ip_out, e_ip);
        chk(tag, "cs_out", 64'(cs_out), 64'(e_cs));
        chk(tag, "sp_out", sp_out, e_sp);
        if (xkind == 2'd1) chk("R4", "no read on stack fault", 64'(seen_rd), 64'd0);
        if (valid && xkind != 2'd1) chk("R9", "first read address", first_addr, a0);
        @(negedge clk);
        chk("R8", "single-cycle pulse", 64'(done | fault), 64'd0);
    endtask

    initial begin
        logic [7:0] ops [4];
        int pulses;
        ops[0] = 8'hC3; ops[1] = 8'hC2; ops[2] = 8'hCB; ops[3] = 8'hCA;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "ip reset", ip_out, 64'd0);
        chk("R10", "cs reset", 64'(cs_out), 64'd0);
        chk("R10", "sp reset", sp_out, 64'd0);
        chk("R10", "flags reset", {60'd0, busy, done, fault, mem_re}, 64'd0);

        // Sweep every encoding, operand size, stack width and mode
        for (int k = 0; k < 4; k++)
            for (int sel = 0; sel < 4; sel++)
                for (int ssz = 0; ssz < 3; ssz++)
                    for (int lm = 0; lm < 2; lm++) begin
                        logic [63:0] spv;
                        spv = (ssz == 2) ? 64'h1800 + 64'(k * 16)
                                         : 64'hABCD_0001_0000_1800 + 64'(k * 16);
                        run_case((sel == 3) ? "R7" : (k >= 2 ? "R3" : "R2"),
                                 ops[k], 2'(sel), lm[0], 2'(ssz), spv, 16'h0020,
                                 64'h1000, 64'h1FFF, '1);
                    end

        run_case("R1", 8'h90, 2'd1, 1'b0, 2'd2, 64'h1800, 16'h0, 64'h1000, 64'h1FFF, '1);
        run_case("R1", 8'hC9, 2'd0, 1'b1, 2'd0, 64'h1800, 16'h0, 64'h1000, 64'h1FFF, '1);

        // Stack window boundaries for each size, near and far
        for (int sel = 0; sel < 3; sel++)
            for (int f = 0; f < 2; f++) begin
                int nd;
                nd = (2 << sel) * (f + 1);
                run_case("R4", f ? 8'hCB : 8'hC3, 2'(sel), 1'b0, 2'd2, 64'h2000 - 64'(nd),
                         16'h0, 64'h1000, 64'h1FFF, '1);
                run_case("R4", f ? 8'hCB : 8'hC3, 2'(sel), 1'b0, 2'd2, 64'h2000 - 64'(nd) + 64'd1,
                         16'h0, 64'h1000, 64'h1FFF, '1);
                run_case("R4", f ? 8'hCB : 8'hC3, 2'(sel), 1'b0, 2'd2, 64'h0FFF,
                         16'h0, 64'h1000, 64'h1FFF, '1);
            end

        // Code limit against masked pointer
        run_case("R5", 8'hC3, 2'd1, 1'b0, 2'd2, 64'h1800, 16'h0, 64'h1000, 64'h1FFF, 64'h5A5A_170E);
        run_case("R5", 8'hC3, 2'd1, 1'b0, 2'd2, 64'h1800, 16'h0, 64'h1000, 64'h1FFF, 64'h5A5A_170F);
        run_case("R5", 8'hCB, 2'd0, 1'b0, 2'd2, 64'h1800, 16'h0, 64'h1000, 64'h1FFF, 64'h170E);
        run_case("R5", 8'hCB, 2'd0, 1'b0, 2'd2, 64'h1800, 16'h0, 64'h1000, 64'h1FFF, 64'h170F);

        // Release wraps inside the stack width
        run_case("R6", 8'hCA, 2'd1, 1'b0, 2'd0, 64'h7777_0000_1234_FFF0, 16'h0040,
                 64'hFF00, 64'hFFFF, '1);
        run_case("R6", 8'hC2, 2'd2, 1'b1, 2'd1, 64'h7777_0000_FFFF_FFF0, 16'hFFFF,
                 64'hFFFF_FF00, 64'hFFFF_FFFF, '1);
        run_case("R6", 8'hCA, 2'd2, 1'b1, 2'd0, 64'h0000_0000_0000_FFF0, 16'h8000,
                 64'hFF00, 64'hFFFF, '1);

        // Start during a busy operation is ignored
        @(negedge clk);
        opcode = 8'hC3; size_sel = 2'd1; stk_size = 2'd2; sp_in = 64'h1900;
        imm = 16'h0; stk_lo = 64'h1000; stk_hi = 64'h1FFF; cs_limit = '1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; opcode = 8'h00;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        pulses = 0;
        for (int i = 0; i < 20; i++) begin
            if (done || fault) pulses++;
            @(negedge clk);
        end
        chk("R11", "pulse count", 64'(pulses), 64'd1);
        chk("R11", "ip after ignored start", ip_out, pat(64'h1900) & 64'hFFFF_FFFF);
        chk("R11", "sp after ignored start", sp_out, 64'h1904);

        finish_run();
    end
endmodule